// File: doc/BRIEF.md
# Masked Priority Interrupt Level Encoder

This block collects thirteen level-sensitive interrupt lines from board peripherals and presents them to a processor that takes its interrupts as a 4-bit encoded level. Each line is synchronized and lands on its own, non-contiguous bit of a 16-bit pending word. A software-owned 16-bit enable word gates that pending word. Among the lines that are both pending and enabled, the one with the smallest source number wins. That number, bit-inverted, drives the level pins.

With the inversion, an idle system shows 0 on the pins and source 0 shows 15. A line that drops clears its pending bit by itself, so software never needs to clear anything. The enable word sits at byte offset 0x00 of a 64-byte register window. It is reached over a small synchronous bus with valid, write, byte address and 16-bit data in each direction.

Top module: `irq_level_encoder`

## Requirements
- R1: After reset the level output is 0 and the enable word reads back as 0.
- R2: Source i feeds pending bit B(i), where B = 11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15 for i = 0..12. Pending bits 1, 2 and 3 have no source and are never set.
- R3: Pending bits follow their lines: a line that goes low stops requesting without any software action.
- R4: A source competes only when its pending bit and the same bit of the enable word are both 1. Enable bits 1, 2 and 3 are stored but never change the output.
- R5: Among the competing sources, the smallest source number wins.
- R6: The output is the winning source number XOR 15. With no competing source it is 0, and source 0 gives 15.
- R7: A write with bus_addr 0x00 stores all 16 bits of bus_wdata into the enable word. A read at 0x00 returns the enable word.
- R8: Reads at any nonzero offset return 0, and writes to them leave the enable word unchanged.
- R9: An enable write changes the output on the second rising edge after it is presented. A line change reaches the output on the third rising edge: two synchronizer stages and then the output register.
- R10: Read data is registered. It is valid from the rising edge that accepts the read request, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 13 | Asynchronous level interrupt lines, index = source number |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset in the register window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irl_code | output | 4 | Encoded interrupt level, inverted winner number |

## Verification
The bench uses the default build, with two synchronizer stages, a 6-bit window address and the enable word at offset 0. This makes the exact latencies of R9 visible at fixed edges. The enable word is full width, so every one of the sixteen bits can be masked on its own, including the three bits that have no source. Every source is tried alone and under its own mask. Priority pairs compete under selective masks, where a masked low-numbered source must yield to a higher-numbered one. Every offset in the window is probed for R8.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;

    localparam int NUM_SRC     = 13;
    localparam int WORD_W      = 16;
    localparam int LVL_W       = 4;
    localparam int ADDR_W      = 6;
    localparam int SYNC_STAGES = 2;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [LVL_W-1:0]   lvl_t;
    typedef logic [NUM_SRC-1:0] src_vec_t;

    localparam lvl_t LVL_NONE = '1;

    typedef struct packed {
        logic              vld;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        word_t             wdata;
    } bus_req_t;

    typedef struct packed {
        logic found;
        lvl_t lvl;
    } prio_res_t;

    // position of a source's request inside the 16-bit word
    function automatic int src_bit(input int idx);
        case (idx)
            0:       return 11;
            1:       return 9;
            2:       return 8;
            3:       return 12;
            4:       return 10;
            5:       return 6;
            6:       return 5;
            7:       return 4;
            8:       return 7;
            9:       return 14;
            10:      return 13;
            11:      return 0;
            default: return 15;
        endcase
    endfunction

    function automatic lvl_t invert_lvl(input lvl_t l);
        return l ^ LVL_NONE;
    endfunction

endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
    parameter int WIDTH  = 13,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= '0;
                    else     chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= '0;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/irq_pend_map.sv
module irq_pend_map
    import irq_enc_pkg::*;
(
    input  src_vec_t lines,
    output word_t    pend_word
);
    generate
        for (genvar b = 0; b < WORD_W; b++) begin : g_bit
            logic hit;
            always_comb begin
                hit = 1'b0;
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (src_bit(i) == b) hit = hit | lines[i];
                end
            end
            assign pend_word[b] = hit;
        end
    endgenerate
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_enc_pkg::*;
(
    input  word_t     qual_word,
    output prio_res_t result
);
    always_comb begin
        result.found = 1'b0;
        result.lvl   = LVL_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (qual_word[src_bit(i)]) begin
                result.found = 1'b1;
                result.lvl   = lvl_t'(i);
            end
        end
    end
endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs
    import irq_enc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] EN_OFFSET = '0
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output word_t    en_word,
    output word_t    rdata
);
    logic  hit;
    word_t en_q;
    word_t rdata_q;

    assign hit = (req.addr == EN_OFFSET);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (req.vld && req.wr && hit) begin
            en_q <= req.wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (req.vld && !req.wr) begin
            rdata_q <= hit ? en_q : '0;
        end
    end

    assign en_word = en_q;
    assign rdata   = rdata_q;
endmodule

// File: rtl/irq_level_encoder.sv
module irq_level_encoder
    import irq_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [12:0]       irq_in,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [5:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic [3:0]        irl_code
);
    src_vec_t  lines_sync;
    word_t     pend_word;
    word_t     en_word;
    word_t     qual_word;
    bus_req_t  req;
    prio_res_t pick;
    lvl_t      code_q;

    assign req.vld   = bus_valid;
    assign req.wr    = bus_write;
    assign req.addr  = bus_addr;
    assign req.wdata = bus_wdata;

    irq_line_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (irq_in),
        .sync_out (lines_sync)
    );

    irq_pend_map u_map (
        .lines     (lines_sync),
        .pend_word (pend_word)
    );

    irq_enable_regs #(.EN_OFFSET('0)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .en_word (en_word),
        .rdata   (bus_rdata)
    );

    assign qual_word = pend_word & en_word;

    irq_prio_sel u_prio (
        .qual_word (qual_word),
        .result    (pick)
    );

    always_ff @(posedge clk) begin
        if (rst)             code_q <= '0;
        else if (pick.found) code_q <= invert_lvl(pick.lvl);
        else                 code_q <= '0;
    end

    assign irl_code = code_q;
endmodule

// File: rtl/irq_level_encoder_chk.sv
module irq_level_encoder_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] pending,
    input logic [15:0] enable,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [5:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic [3:0]  code
);
    // R2: unsourced pending bits stay clear
    a_r2_unsourced_clear: assert property (@(posedge clk) disable iff (rst)
        pending[3:1] == 3'b000);

    // R6: nothing competing gives a zero output one edge later
    a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
        ((pending & enable) == 16'h0) |=> (code == 4'h0));

    // R5: source 0 (bit 11) beats everyone
    a_r5_top_wins: assert property (@(posedge clk) disable iff (rst)
        (pending[11] && enable[11]) |=> (code == 4'hF));

    // R4: a nonzero output needs a qualifying source the cycle before
    a_r4_needs_qual: assert property (@(posedge clk) disable iff (rst)
        (code != 4'h0) |-> ($past(pending & enable) != 16'h0));

    // R7: mapped write lands in the enable word
    a_r7_write_stores: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_addr == 6'h00) |=> (enable == $past(bus_wdata)));

    // R8: unmapped write leaves the enable word alone
    a_r8_unmapped_write: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_addr != 6'h00) |=> $stable(enable));
endmodule

bind irq_level_encoder irq_level_encoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pending   (pend_word),
    .enable    (en_word),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .code      (irl_code)
);

// File: tb/tb_irq_level_encoder.sv
module tb_irq_level_encoder;
    logic        clk = 1'b0;
    logic        rst;
    logic [12:0] irq_in;
    logic        bus_valid;
    logic        bus_write;
    logic [5:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [3:0]  irl_code;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #10 clk = ~clk;   // 50 MHz

    irq_level_encoder dut (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irl_code(irl_code)
    );

    localparam int BITPOS [13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};

    typedef struct packed {
        logic [12:0] irq;
        logic [15:0] en;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{13'h0000, 16'hFFFF},
        '{13'h1FFF, 16'hFFFF},
        '{13'h1FFF, 16'h0000},
        '{13'h1FFF, 16'h000E},
        '{13'h0003, 16'hF7FF},
        '{13'h1800, 16'h8001},
        '{13'h1800, 16'h8000},
        '{13'h0210, 16'h6000},
        '{13'h0120, 16'h00C0},
        '{13'h1FFE, 16'hF0F1}
    };

    function automatic logic [3:0] ref_code(input logic [12:0] irq, input logic [15:0] en);
        int lvl = 15;
        for (int i = 0; i < 13; i++)
            if (irq[i] && en[BITPOS[i]] && i < lvl) lvl = i;
        return 4'(lvl) ^ 4'hF;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic bus_rd(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        @(negedge clk);
        bus_valid = 0;
        d = bus_rdata;
    endtask

    task automatic apply(input logic [12:0] irq, input logic [15:0] en, input string req);
        bus_wr(6'h00, en);
        irq_in = irq;
        repeat (4) @(negedge clk);
        check(req, {12'h0, irl_code}, {12'h0, ref_code(irq, en)});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        rst = 1; irq_in = '0; bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        check("R1 code", {12'h0, irl_code}, 16'h0);
        bus_rd(6'h00, rd);
        check("R1 enable", rd, 16'h0);

        // vector table: R4 R5 R6
        for (int v = 0; v < NVEC; v++)
            apply(VECS[v].irq, VECS[v].en, "R5/R6 vector");

        // R2 each source alone under its own bit only, then under the rest
        for (int i = 0; i < 13; i++) begin
            apply(13'(1) << i, 16'(1) << BITPOS[i], "R2 single");
            apply(13'(1) << i, ~(16'(1) << BITPOS[i]), "R4 masked single");
        end

        // R5 pairs
        for (int i = 0; i < 12; i++)
            apply((13'(1) << i) | (13'(1) << (i + 1)), 16'hFFFF, "R5 pair");
        apply(13'h1001, 16'h8000, "R5 low masked yields");

        // R4 unsourced enable bits have no effect
        apply(13'h1FFF, 16'h000E, "R4 unsourced bits");

        // R3 line drop clears without software
        apply(13'h0001, 16'hFFFF, "R3 setup");
        irq_in = '0;
        repeat (4) @(negedge clk);
        check("R3 drop", {12'h0, irl_code}, 16'h0);

        // R7 readback of all bits
        bus_wr(6'h00, 16'hA5C3);
        bus_rd(6'h00, rd);
        check("R7 readback", rd, 16'hA5C3);

        // R8 unmapped offsets
        for (int a = 1; a < 64; a++) begin
            bus_wr(6'(a), 16'h1234);
            bus_rd(6'(a), rd);
            check("R8 unmapped read", rd, 16'h0);
        end
        bus_rd(6'h00, rd);
        check("R8 enable untouched", rd, 16'hA5C3);

        // R10 read data holds after request
        @(negedge clk);
        check("R10 hold", bus_rdata, 16'hA5C3);

        // R9 enable write latency: source 12 pending, enable off
        bus_wr(6'h00, 16'h0000);
        irq_in = 13'h1000;
        repeat (4) @(negedge clk);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 6'h00; bus_wdata = 16'h8000;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
        check("R9 enable edge1", {12'h0, irl_code}, 16'h0);
        @(negedge clk);
        check("R9 enable edge2", {12'h0, irl_code}, 16'h3);

        // R9 line latency: source 11 rises
        bus_wr(6'h00, 16'h0001);
        irq_in = 13'h0000;
        repeat (4) @(negedge clk);
        irq_in = 13'h0800;
        repeat (2) @(negedge clk);
        check("R9 line edge2", {12'h0, irl_code}, 16'h0);
        @(negedge clk);
        check("R9 line edge3", {12'h0, irl_code}, 16'h4);

        // R1 reset mid-run
        irq_in = 13'h1FFF;
        bus_wr(6'h00, 16'hFFFF);
        repeat (4) @(negedge clk);
        rst = 1;
        @(negedge clk);
        irq_in = '0;
        rst = 0;
        @(negedge clk);
        check("R1 reset code", {12'h0, irl_code}, 16'h0);
        bus_rd(6'h00, rd);
        check("R1 reset enable", rd, 16'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule